// File: doc/BRIEF.md
# Quad Periodic Countdown Timer

This block holds four independent down-counters behind a word-wide register port. Each timer has a length register and a live-count register, and drives its own interrupt line. A shared start word launches timers in periodic mode. Each timer owns a 4-bit field in that word. A running timer with a nonzero length counts down once per tick. When it reaches zero it reloads its length on that same tick and pulses its interrupt. The timers therefore keep firing until their length is rewritten.

The tick is a single-cycle enable made from the system clock by a divider of `CLK_DIV` cycles. With the default of 50 this gives 1 MHz ticks from a 50 MHz clock. All timers share the tick. The register port is a plain single-cycle write strobe. Read data is combinational from the address. The port is always ready, so it has no back-pressure and no handshake.

Register offsets, in bytes, are word-aligned. The length of timer n is at 4·n. The start word is at 4·N_TMR. The live count of timer n is at 4·(N_TMR+1+n). With the defaults these are 0x00–0x0C, 0x10 and 0x14–0x20.

Top module: `quad_timer`

## Requirements
- R1: After reset every length and count reads 0, every interrupt output is low, and no timer runs.
- R2: A write to the length register of timer n (offset 4·n) stores the value as its length and sets its count to that same value at that clock edge, whether or not the timer runs.
- R3: A read of offset 4·n returns the stored length of timer n, and a read of offset 0x14+4·n returns its live count in the same cycle.
- R4: A write to the start word (offset 0x10) starts each timer n whose field bits [4n+3:4n] are nonzero, loading its count from its stored length. A zero field leaves that timer unchanged, whether it is idle or running. Reads of the start word return 0.
- R5: The tick occurs once every `CLK_DIV` clocks, the first on the `CLK_DIV`-th clock after reset. A running timer with nonzero length decrements by one per tick. An idle timer keeps its count.
- R6: When a running timer is at 1 on a tick, its count reloads to its length and its interrupt output is high for exactly one clock. The period is therefore length × `CLK_DIV` clocks.
- R7: A timer whose length is 0 never raises its interrupt and its count stays 0.
- R8: The four interrupt outputs are independent. Each pulses only on the expiry of its own timer.
- R9: Reads of unmapped or non-word-aligned offsets return 0. Writes to them change no register.
- R10: A length write that coincides with a tick takes priority for that timer: no interrupt is raised for that tick and the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| tmr_irq | output | N_TMR | Per-timer one-clock expiry pulse |

## Verification
Some checks hold on every cycle, and the assertions cover these. A count never exceeds its length. An interrupt appears only right after a tick, and then with the count equal to the length. A zero length keeps its line silent. An idle timer holds its count. A length write suppresses expiry. Unmapped writes leave every length untouched. The tick never fires on two adjacent clocks.

Other behaviour needs the bench's scenarios, which compare against an independent model. These are the exact expiry period in clocks and the phase of the first tick after reset. They also include the effect of zero fields in a start word, the independence of the four lines under mixed lengths, and the collision between a length write and an expiring tick.

// File: rtl/qt_pkg.sv
package qt_pkg;

  // Width of each timer's field in the start word.
  localparam int FIELD_W = 4;

  // Register region selected by an address.
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_LEN  = 2'd1,
    REG_CTRL = 2'd2,
    REG_VAL  = 2'd3
  } region_e;

endpackage

// File: rtl/qt_tick_gen.sv
module qt_tick_gen #(
  parameter int CLK_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (CLK_DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      localparam int DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      // R5: ticks are never back to back when the divider exceeds one
      p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/qt_decode.sv
module qt_decode
  import qt_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  output region_e                    region,
  output logic [$clog2(N_TMR)-1:0]   idx
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(N_TMR);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    region = REG_NONE;
    idx    = '0;
    if (addr[1:0] == 2'b00) begin
      if (word < WORD_W'(N_TMR)) begin
        region = REG_LEN;
        idx    = IDX_W'(word);
      end else if (word == WORD_W'(N_TMR)) begin
        region = REG_CTRL;
      end else if (word < WORD_W'(2 * N_TMR + 1)) begin
        region = REG_VAL;
        idx    = IDX_W'(word - WORD_W'(N_TMR + 1));
      end
    end
  end

endmodule

// File: rtl/qt_counter.sv
module qt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             len_wr_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             run_q, irq_q;
  logic             at_end;

  assign at_end = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (len_wr_i) begin
        lim_q <= wdata_i;
        cnt_q <= wdata_i;
      end else if (start_i) begin
        run_q <= 1'b1;
        cnt_q <= lim_q;
      end else if (tick_i && run_q && (lim_q != '0)) begin
        if (at_end) begin
          cnt_q <= lim_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign limit_o = lim_q;
  assign irq_o   = irq_q;

  // R2: the live count never exceeds the stored length
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R6: an interrupt only follows a tick that no bus write overrode
  p_irq_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(tick_i) && !$past(len_wr_i) && !$past(start_i)));

  // R6: at the pulse the count has already reloaded
  p_irq_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == lim_q));

  // R7: zero length stays silent
  p_zero_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |=> !irq_q);

  // R5: an idle timer holds its count
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !len_wr_i && !start_i) |=> $stable(cnt_q));

  // R10: a length write wins over a coinciding expiry
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_wr_i |=> (!irq_q && cnt_q == $past(wdata_i)));

endmodule

// File: rtl/quad_timer.sv
module quad_timer
  import qt_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int CLK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [N_TMR-1:0]  tmr_irq
);

  localparam int IDX_W = $clog2(N_TMR);

  logic                 tick;
  region_e              region;
  logic [IDX_W-1:0]     idx;
  logic [CNT_W-1:0]     cnt_a [N_TMR];
  logic [CNT_W-1:0]     lim_a [N_TMR];
  logic [N_TMR-1:0]     len_wr, start;

  qt_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  qt_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .idx    (idx)
  );

  generate
    for (genvar n = 0; n < N_TMR; n++) begin : g_tmr
      assign len_wr[n] = bus_wr && (region == REG_LEN) && (idx == IDX_W'(n));
      assign start[n]  = bus_wr && (region == REG_CTRL) &&
                         (|bus_wdata[n*FIELD_W +: FIELD_W]);

      qt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .len_wr_i (len_wr[n]),
        .start_i  (start[n]),
        .wdata_i  (bus_wdata),
        .count_o  (cnt_a[n]),
        .limit_o  (lim_a[n]),
        .irq_o    (tmr_irq[n])
      );

      // R9: writes outside the map leave this timer's length alone
      p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == REG_NONE) |=> (lim_a[n] == $past(lim_a[n])));
    end
  endgenerate

  always_comb begin
    unique case (region)
      REG_LEN:  bus_rdata = lim_a[idx];
      REG_VAL:  bus_rdata = cnt_a[idx];
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: tb/quad_timer_tb.sv
module quad_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tmr_irq;

  int n_vec = 0;
  int n_bad = 0;
  bit chk_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_timer #(.N_TMR(4), .CNT_W(32), .ADDR_W(8), .CLK_DIV(DIV)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_irq   (tmr_irq)
  );

  // Reference model built from the requirements
  logic [31:0] ref_cnt [4];
  logic [31:0] ref_lim [4];
  logic [3:0]  ref_run;
  logic [3:0]  ref_irq;
  int          ref_div;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_div <= 0;
      ref_run <= '0;
      ref_irq <= '0;
      for (int n = 0; n < 4; n++) begin
        ref_cnt[n] <= '0;
        ref_lim[n] <= '0;
      end
    end else begin
      ref_div <= (ref_div == DIV - 1) ? 0 : ref_div + 1;
      for (int n = 0; n < 4; n++) begin
        ref_irq[n] <= 1'b0;
        if (bus_wr && bus_addr == 8'(4 * n)) begin
          ref_lim[n] <= bus_wdata;
          ref_cnt[n] <= bus_wdata;
        end else if (bus_wr && bus_addr == 8'h10 && bus_wdata[4*n +: 4] != 4'h0) begin
          ref_run[n] <= 1'b1;
          ref_cnt[n] <= ref_lim[n];
        end else if (ref_div == DIV - 1 && ref_run[n] && ref_lim[n] != 0) begin
          if (ref_cnt[n] <= 1) begin
            ref_cnt[n] <= ref_lim[n];
            ref_irq[n] <= 1'b1;
          end else begin
            ref_cnt[n] <= ref_cnt[n] - 1;
          end
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 8'h10) return ref_lim[int'(a >> 2)];
    if (a >= 8'h14 && a <= 8'h20) return ref_cnt[int'((a - 8'h14) >> 2)];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R3 reads, R8 lines)
  always @(negedge clk) begin
    if (chk_en) begin
      chk("R3 live read", bus_rdata, exp_read(bus_addr));
      chk("R8 irq lines", {28'h0, tmr_irq}, {28'h0, ref_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cyc;
    int hits;
    int seed;
    seed = $urandom(32'h5eed_0042);

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk_en = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(8'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", {28'h0, tmr_irq}, 32'h0);

    // R2 / R3: length write is visible at once in both registers
    wr(8'h00, 32'd5);
    rd(8'h14, d); chk("R2 count loaded", d, 32'd5);
    rd(8'h00, d); chk("R3 length read", d, 32'd5);

    // R5: idle timer keeps its count across ticks
    repeat (3 * DIV) @(negedge clk);
    rd(8'h14, d); chk("R5 idle hold", d, 32'd5);

    // R4: start timer 0 only; timer 3 stays idle
    wr(8'h0C, 32'd9);
    wr(8'h10, 32'h0000_0001);
    rd(8'h10, d); chk("R4 start word reads 0", d, 32'h0);

    // R6: period = length * DIV clocks
    cyc = 0;
    while (tmr_irq[0] !== 1'b1 && cyc < 1000) begin @(negedge clk); cyc++; end
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (tmr_irq[0] !== 1'b1 && cyc < 1000);
    chk("R6 period clocks", 32'(cyc), 32'(5 * DIV));
    rd(8'h20, d); chk("R4 zero field untouched", d, 32'd9);

    // R7: zero length never fires
    wr(8'h04, 32'd0);
    wr(8'h10, 32'h0000_0010);
    hits = 0;
    repeat (10 * DIV) begin @(negedge clk); if (tmr_irq[1]) hits++; end
    chk("R7 zero length pulses", 32'(hits), 32'h0);
    rd(8'h18, d); chk("R7 zero length count", d, 32'h0);

    // R9: unmapped and unaligned accesses
    wr(8'h24, 32'h55);
    wr(8'h02, 32'd99);
    rd(8'h24, d); chk("R9 unmapped read", d, 32'h0);
    rd(8'h02, d); chk("R9 unaligned read", d, 32'h0);
    rd(8'h00, d); chk("R9 length unchanged", d, 32'd5);

    // R10: length write on the very tick that would expire timer 0
    wr(8'h00, 32'd1);
    forever begin
      @(negedge clk);
      if (ref_div == DIV - 1) break;
    end
    #1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'd7;
    @(negedge clk);
    chk("R10 no expiry pulse", {31'h0, tmr_irq[0]}, 32'h0);
    #1; bus_wr = 1'b0;
    rd(8'h14, d); chk("R10 count takes write", d, 32'd7);

    // Constrained random traffic checked by the model (R5, R6, R8)
    wr(8'h10, 32'h0000_1111);
    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = int'($urandom_range(0, 11));
      if (pick == 0) begin
        logic [31:0] len;
        int sel;
        sel = int'($urandom_range(0, 9));
        if (sel == 0)      len = 32'h0;
        else if (sel == 1) len = 32'hFFFF_FFF0;
        else               len = 32'($urandom_range(1, 12));
        wr(8'(4 * $urandom_range(0, 3)), len);
      end else if (pick == 1) begin
        wr(8'h10, $urandom & 32'h0000_FFFF);
      end else if (pick == 2) begin
        wr(8'($urandom_range(8'h21, 8'hFF)), $urandom);
      end else begin
        @(negedge clk); #1;
        bus_wr = 1'b0;
        bus_addr = 8'($urandom_range(0, 9) * 4);
      end
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule